// File: doc/BRIEF.md
# Serial Command-Prefixed Register Port

This block is the serial slave front end for a small converter register map. A host drives an active-low chip-select, a serial clock that idles high, and a data-in line. The block answers on data-out. Each access opens with an 8-bit command byte that gives the direction and a 6-bit register address. A data phase follows, and its length of 8, 16 or 24 bits depends on the register that was named. When the data phase ends, the port expects a new command byte. The host can run several accesses back to back under one chip-select, or raise chip-select between them.

The serial pins are brought into the system clock domain through two-stage synchronisers. A bit is taken on each rising edge of the synchronised serial clock. The port holds:

- plain storage for the I/O-setup, test, checksum and two calibration-coefficient registers;
- a fixed identity value;
- a live view of a status byte and two channel results, taken from input ports that stand in for the conversion engine.

A host can recover from a lost framing by holding data-in high for 32 serial clocks with chip-select low. This returns both the port and all of its registers to their defaults.

The state machine has three states:

- `ST_CMD` collects the command byte.
- `ST_WRITE` shifts in write data.
- `ST_READ` shifts out read data.

It has these transitions:

- From `ST_CMD` to `ST_WRITE` or `ST_READ` on the 8th command bit, chosen by the direction bit.
- From `ST_WRITE` or `ST_READ` back to `ST_CMD` on the last data bit.
- From any state to `ST_CMD` when chip-select is released (abort).
- From any state to `ST_CMD` when the 32-ones resync fires.

Top module: `sreg_link`

## Requirements
- R1: After reset the port expects a command byte and data-out is 0. The I/O-setup register (01h) reads 30h. The zero-scale (06h) and full-scale (07h) coefficients read 800000h. The test register (03h) and checksum register (05h) read 0.
- R2: A command byte is sent MSB first. Its bit 7 is reserved and must be 0, bit 6 is the direction (1 = read, 0 = write), and bits 5..0 are the address. Data-in is sampled on the serial clock rising edge. Read data is presented MSB first on data-out and holds steady while the serial clock is low. Data-out is 0 outside a read data phase.
- R3: The data phase is 8 bits for addresses 00h, 01h, 02h and 04h. It is 16 bits for 05h and 24 bits for 03h, 06h and 07h. Written values read back unchanged from 01h, 03h, 05h, 06h and 07h.
- R4: Addresses 08h and 0Ah return the channel result selected by address bit 1 (0 = channel 0, 1 = channel 1). With `wide_data`=1 the phase is 24 bits and carries the full result. With `wide_data`=0 it is 16 bits and carries result bits 23..8.
- R5: Address 02h reads {REV_CODE, 4'h4}, and writes to it are discarded.
- R6: A write to 06h takes effect only while `conv_idle`=1. Otherwise it is discarded.
- R7: With chip-select low, 32 consecutive ones on data-in return the port to command-expected and every register to its R1 default. A run of 31 ones does not do this.
- R8: Raising chip-select in the middle of a command byte or a data phase aborts the access with no register change. The next access starts with a command byte.
- R9: These accesses use an 8-bit data phase, read as 0, and discard writes: commands with bit 7 set, and addresses other than 01h–08h and 0Ah. Address 00h reads 0. Address 04h reads `status_in` and discards writes.
- R10: After a data phase completes, the next 8 bits under the same chip-select are taken as a new command.
- R11: Read data is captured when the command byte ends. A change of the source during the data phase does not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| conv_idle | input | 1 | Converter idle; gates zero-scale writes |
| wide_data | input | 1 | Channel result width select (1 = 24 bits) |
| status_in | input | 8 | Converter status byte shown at 04h |
| chan0_data | input | 24 | Channel 0 conversion result |
| chan1_data | input | 24 | Channel 1 conversion result |

## Verification
All 64 addresses are read under both settings of `wide_data`. A wrong phase length shows up as misaligned bits in the read value and in every access that follows. Distinct high and low bit patterns in the two channel results show whether channel selection and 16-bit truncation are correct. Each writable register gets three patterns: alternating bits, a walking pattern and all ones within its width. These separate bit-order, width and gating faults. Separate runs cover the resync boundary (31 ones against 32), aborts in the command and data phases, back-to-back accesses, and a source change in mid-read.

// File: rtl/sreg_link_pkg.sv
package sreg_link_pkg;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } link_state_e;

    localparam int DATA_W = 24;

    localparam logic [5:0] A_COMM  = 6'h00;
    localparam logic [5:0] A_IOSET = 6'h01;
    localparam logic [5:0] A_IDENT = 6'h02;
    localparam logic [5:0] A_TEST  = 6'h03;
    localparam logic [5:0] A_STAT  = 6'h04;
    localparam logic [5:0] A_CKSUM = 6'h05;
    localparam logic [5:0] A_ZERO  = 6'h06;
    localparam logic [5:0] A_FULL  = 6'h07;
    localparam logic [5:0] A_CH0   = 6'h08;
    localparam logic [5:0] A_CH1   = 6'h0A;

    // Data phase length for a decoded command; reserved bit forces 8.
    function automatic logic [4:0] phase_len(input logic rsv,
                                             input logic [5:0] adr,
                                             input logic wide);
        logic [4:0] n;
        n = 5'd8;
        if (!rsv) begin
            unique case (adr)
                A_CKSUM:                n = 5'd16;
                A_TEST, A_ZERO, A_FULL: n = 5'd24;
                A_CH0, A_CH1:           n = wide ? 5'd24 : 5'd16;
                default:                n = 5'd8;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/sreg_link_sync.sv
module sreg_link_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[gi] <= RST_VAL;
                end else if (gi == 0) begin
                    pipe[gi] <= d;
                end else begin
                    pipe[gi] <= pipe[(gi == 0) ? 0 : gi - 1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sreg_link_resync.sv
module sreg_link_resync #(
    parameter int ONES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bit_stb,
    input  logic bit_val,
    output logic fire
);
    localparam int CW = $clog2(ONES + 1);

    logic [CW-1:0] run_cnt;

    assign fire = active && bit_stb && bit_val && (run_cnt == CW'(ONES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!active || fire) begin
            run_cnt <= '0;
        end else if (bit_stb) begin
            run_cnt <= bit_val ? run_cnt + 1'b1 : '0;
        end
    end

    // R7: the run counter never reaches the threshold itself
    assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(ONES));
    // R7: leaving chip-select clears the run
    assert_run_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> run_cnt == '0);
endmodule

// File: rtl/sreg_link_regs.sv
module sreg_link_regs
    import sreg_link_pkg::*;
#(
    parameter logic [3:0] REV_CODE = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [6:0]        rd_sel,
    input  logic              rd_wide,
    input  logic              conv_idle,
    input  logic [7:0]        status_in,
    input  logic [DATA_W-1:0] chan0_data,
    input  logic [DATA_W-1:0] chan1_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [7:0]        IOSET_RST = 8'h30;
    localparam logic [DATA_W-1:0] COEF_RST  = 24'h800000;

    logic [7:0]        ioset_q;
    logic [DATA_W-1:0] test_q;
    logic [15:0]       cksum_q;
    logic [DATA_W-1:0] zero_q;
    logic [DATA_W-1:0] full_q;
    logic [DATA_W-1:0] ch_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ioset_q <= IOSET_RST;
            test_q  <= '0;
            cksum_q <= '0;
            zero_q  <= COEF_RST;
            full_q  <= COEF_RST;
        end else if (clr) begin
            ioset_q <= IOSET_RST;
            test_q  <= '0;
            cksum_q <= '0;
            zero_q  <= COEF_RST;
            full_q  <= COEF_RST;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_IOSET: ioset_q <= wr_data[7:0];
                A_TEST:  test_q  <= wr_data;
                A_CKSUM: cksum_q <= wr_data[15:0];
                A_ZERO:  if (conv_idle) zero_q <= wr_data;
                A_FULL:  full_q  <= wr_data;
                default: ;
            endcase
        end
    end

    assign ch_sel = rd_sel[1] ? chan1_data : chan0_data;

    always_comb begin
        rd_data = '0;
        if (!rd_sel[6]) begin
            unique case (rd_sel[5:0])
                A_IOSET: rd_data = {16'h0, ioset_q};
                A_IDENT: rd_data = {16'h0, REV_CODE, 4'h4};
                A_TEST:  rd_data = test_q;
                A_STAT:  rd_data = {16'h0, status_in};
                A_CKSUM: rd_data = {8'h0, cksum_q};
                A_ZERO:  rd_data = zero_q;
                A_FULL:  rd_data = full_q;
                A_CH0, A_CH1: rd_data = rd_wide ? ch_sel : {8'h0, ch_sel[23:8]};
                default: rd_data = '0;
            endcase
        end
    end

    // R6: a busy converter locks the zero-scale coefficient
    assert_zero_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && wr_addr == A_ZERO && !conv_idle) |=> $stable(zero_q));
    // R7: resync restores defaults
    assert_clear_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ioset_q == IOSET_RST && zero_q == COEF_RST && full_q == COEF_RST
                 && test_q == '0 && cksum_q == '0));
endmodule

// File: rtl/sreg_link.sv
module sreg_link
    import sreg_link_pkg::*;
#(
    parameter logic [3:0] REV_CODE    = 4'h1,
    parameter int         SYNC_STAGES = 2,
    parameter int         RESYNC_ONES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    input  logic        conv_idle,
    input  logic        wide_data,
    input  logic [7:0]  status_in,
    input  logic [23:0] chan0_data,
    input  logic [23:0] chan1_data
);
    localparam int CMD_BITS = 8;

    logic [2:0] pins_s;
    logic       cs_n_s, sclk_s, sdi_s, sclk_d;
    logic       rise, cs_act, fire;

    link_state_e       state_q, state_d;
    logic [4:0]        bit_cnt;
    logic [4:0]        len_q;
    logic [6:0]        cmd_sr;
    logic [6:0]        cmd_q;
    logic [22:0]       rx_sr;
    logic [DATA_W-1:0] tx_sr;

    logic [7:0]        cmd_next;
    logic [DATA_W-1:0] rx_next;
    logic [4:0]        new_len;
    logic [DATA_W-1:0] rd_data;
    logic              last_bit, cmd_done, commit;

    sreg_link_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
    );
    assign {cs_n_s, sclk_s, sdi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    assign rise   = sclk_s && !sclk_d;
    assign cs_act = !cs_n_s;

    sreg_link_resync #(.ONES(RESYNC_ONES)) u_resync (
        .clk(clk), .rst_n(rst_n), .active(cs_act), .bit_stb(rise),
        .bit_val(sdi_s), .fire(fire)
    );

    assign cmd_next = {cmd_sr, sdi_s};
    assign rx_next  = {rx_sr, sdi_s};
    assign new_len  = phase_len(cmd_next[7], cmd_next[5:0], wide_data);
    assign last_bit = (bit_cnt == len_q - 5'd1);
    assign cmd_done = (state_q == ST_CMD) && (bit_cnt == 5'(CMD_BITS - 1));
    assign commit   = rise && cs_act && !fire && (state_q == ST_WRITE)
                      && last_bit && !cmd_q[6];

    sreg_link_regs #(.REV_CODE(REV_CODE)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(fire), .wr_en(commit),
        .wr_addr(cmd_q[5:0]), .wr_data(rx_next),
        .rd_sel({cmd_next[7], cmd_next[5:0]}), .rd_wide(wide_data),
        .conv_idle(conv_idle), .status_in(status_in),
        .chan0_data(chan0_data), .chan1_data(chan1_data), .rd_data(rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_act || fire) begin
            state_d = ST_CMD;
        end else if (rise) begin
            unique case (state_q)
                ST_CMD:   if (cmd_done) state_d = cmd_next[6] ? ST_READ : ST_WRITE;
                ST_WRITE: if (last_bit) state_d = ST_CMD;
                ST_READ:  if (last_bit) state_d = ST_CMD;
                default:  state_d = ST_CMD;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            bit_cnt <= '0;
            len_q   <= 5'(CMD_BITS);
            cmd_sr  <= '0;
            cmd_q   <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else begin
            state_q <= state_d;
            if (!cs_act || fire) begin
                bit_cnt <= '0;
                len_q   <= 5'(CMD_BITS);
                cmd_sr  <= '0;
                tx_sr   <= '0;
            end else if (rise) begin
                unique case (state_q)
                    ST_CMD: begin
                        cmd_sr <= cmd_next[6:0];
                        if (cmd_done) begin
                            cmd_q   <= {cmd_next[7], cmd_next[5:0]};
                            len_q   <= new_len;
                            bit_cnt <= '0;
                            tx_sr   <= rd_data << (5'd24 - new_len);
                        end else begin
                            bit_cnt <= bit_cnt + 5'd1;
                        end
                    end
                    ST_WRITE: begin
                        rx_sr   <= rx_next[22:0];
                        bit_cnt <= last_bit ? 5'd0 : bit_cnt + 5'd1;
                        if (last_bit) len_q <= 5'(CMD_BITS);
                    end
                    ST_READ: begin
                        tx_sr   <= tx_sr << 1;
                        bit_cnt <= last_bit ? 5'd0 : bit_cnt + 5'd1;
                        if (last_bit) len_q <= 5'(CMD_BITS);
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    // Output logic
    always_comb begin
        sdo = 1'b0;
        if (state_q == ST_READ) sdo = tx_sr[DATA_W-1];
    end

    // R8: a released chip-select always lands in the command state
    assert_abort_to_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state_q == ST_CMD && bit_cnt == '0));
    // R7: a resync event leaves the port expecting a command
    assert_resync_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == ST_CMD && bit_cnt == '0));
    // R3: the bit counter stays inside the current phase length
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < len_q);
    // R2: data-out stays low outside a read phase
    assert_sdo_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ) |-> !sdo);
    // R3: data phases take one of the three lengths
    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == 5'd8 || len_q == 5'd16 || len_q == 5'd24));
endmodule

// File: tb/sreg_link_tb.sv
module sreg_link_tb;
    localparam logic [3:0] REV = 4'h1;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic sdi = 1'b0;
    logic sdo;
    logic conv_idle = 1'b1;
    logic wide_data = 1'b0;
    logic [7:0]  status_in = 8'h05;
    logic [23:0] chan0_data = 24'hA5C3E1;
    logic [23:0] chan1_data = 24'h1B2D4F;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0]  m_ioset;
    logic [23:0] m_test, m_zero, m_full;
    logic [15:0] m_cksum;

    always #2.5 clk = ~clk;

    sreg_link #(.REV_CODE(REV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .conv_idle(conv_idle), .wide_data(wide_data), .status_in(status_in),
        .chan0_data(chan0_data), .chan1_data(chan1_data)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %06h expected %06h", tag, got, exp);
        end
    endtask

    function automatic int exp_len(input logic [7:0] cmd);
        int n;
        n = 8;
        if (cmd[7] == 1'b0) begin
            case (cmd[5:0])
                6'h05: n = 16;
                6'h03, 6'h06, 6'h07: n = 24;
                6'h08, 6'h0A: n = wide_data ? 24 : 16;
                default: n = 8;
            endcase
        end
        return n;
    endfunction

    function automatic logic [23:0] exp_read(input logic [7:0] cmd);
        logic [23:0] v;
        logic [23:0] ch;
        v = 24'h0;
        ch = cmd[1] ? chan1_data : chan0_data;
        if (cmd[7] == 1'b0) begin
            case (cmd[5:0])
                6'h01: v = {16'h0, m_ioset};
                6'h02: v = {16'h0, REV, 4'h4};
                6'h03: v = m_test;
                6'h04: v = {16'h0, status_in};
                6'h05: v = {8'h0, m_cksum};
                6'h06: v = m_zero;
                6'h07: v = m_full;
                6'h08, 6'h0A: v = wide_data ? ch : {8'h0, ch[23:8]};
                default: v = 24'h0;
            endcase
        end
        return v;
    endfunction

    task automatic model_defaults();
        m_ioset = 8'h30; m_test = 24'h0; m_cksum = 16'h0;
        m_zero = 24'h800000; m_full = 24'h800000;
    endtask

    task automatic bit_io(input logic b, output logic o);
        sclk = 1'b0; sdi = b;
        tick(HALF);
        o = sdo;
        sclk = 1'b1;
        tick(HALF);
    endtask

    task automatic shift(input logic [23:0] val, input int n, output logic [23:0] got);
        logic o;
        got = 24'h0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_io(val[i], o);
            got = {got[22:0], o};
        end
    endtask

    // One access inside an already selected session
    task automatic frame(input logic [7:0] cmd, input logic [23:0] wd, output logic [23:0] rd);
        logic [23:0] g;
        shift({16'h0, cmd}, 8, g);
        shift(wd, exp_len(cmd), rd);
    endtask

    task automatic access(input logic [7:0] cmd, input logic [23:0] wd, output logic [23:0] rd);
        cs_n = 1'b0; tick(4);
        frame(cmd, wd, rd);
        tick(2); cs_n = 1'b1; tick(6);
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [23:0] v);
        access({2'b01, a}, 24'h0, v);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [23:0] v);
        logic [23:0] g;
        access({2'b00, a}, v, g);
        check("R2 sdo low in write phase", g, 24'h0);
    endtask

    task automatic check_all(input string tag);
        logic [23:0] v;
        rd_reg(6'h01, v); check(tag, v, exp_read(8'h41));
        rd_reg(6'h03, v); check(tag, v, exp_read(8'h43));
        rd_reg(6'h05, v); check(tag, v, exp_read(8'h45));
        rd_reg(6'h06, v); check(tag, v, exp_read(8'h46));
        rd_reg(6'h07, v); check(tag, v, exp_read(8'h47));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] v, v2;
        logic [23:0] pats [3];
        model_defaults();
        tick(5); rst_n = 1'b1; tick(5);

        // R1 reset state
        check("R1 sdo after reset", {23'h0, sdo}, 24'h0);
        check_all("R1 defaults");

        // R3 R4 R5 R9 sweep of all addresses, both widths
        for (int w = 0; w < 2; w++) begin
            wide_data = w[0];
            for (int a = 0; a < 64; a++) begin
                rd_reg(a[5:0], v);
                check("R3/R4/R9 read sweep", v, exp_read({2'b01, a[5:0]}));
            end
        end
        wide_data = 1'b1;
        rd_reg(6'h0A, v); check("R4 channel 1 wide", v, 24'h1B2D4F);
        wide_data = 1'b0;
        rd_reg(6'h08, v); check("R4 channel 0 narrow", v, 24'h00A5C3);
        rd_reg(6'h02, v); check("R5 identity", v, {16'h0, REV, 4'h4});

        // R2 R3 write patterns
        for (int p = 0; p < 3; p++) begin
            pats[0] = 24'hAAAAAA ^ {24{p[0]}};
            pats[1] = 24'h000001 << (p * 7 + 1);
            pats[2] = 24'hFFFFFF;
            for (int k = 0; k < 3; k++) begin
                v = pats[k] ^ {8'h0, p[7:0], 8'h0};
                wr_reg(6'h01, v); m_ioset = v[7:0];
                wr_reg(6'h03, v); m_test = v;
                wr_reg(6'h05, v); m_cksum = v[15:0];
                wr_reg(6'h06, v); m_zero = v;
                wr_reg(6'h07, v ^ 24'h0F0F0F); m_full = v ^ 24'h0F0F0F;
                check_all("R3 write readback");
            end
        end

        // R5 R9 discarded writes
        wr_reg(6'h02, 24'hFF);
        rd_reg(6'h02, v); check("R5 identity write ignored", v, {16'h0, REV, 4'h4});
        wr_reg(6'h04, 24'hFF);
        rd_reg(6'h04, v); check("R9 status write ignored", v, 24'h05);
        wr_reg(6'h00, 24'hFF);
        wr_reg(6'h1F, 24'hFF);
        wr_reg(6'h09, 24'hFF);
        access(8'h81, 24'hFF, v);
        access(8'hC1, 24'h0, v); check("R9 reserved-bit read", v, 24'h0);
        check_all("R9 no side effects");

        // R6 gating
        conv_idle = 1'b0;
        wr_reg(6'h06, 24'h123456);
        rd_reg(6'h06, v); check("R6 busy write ignored", v, m_zero);
        conv_idle = 1'b1;
        wr_reg(6'h06, 24'h123456); m_zero = 24'h123456;
        rd_reg(6'h06, v); check("R6 idle write taken", v, 24'h123456);

        // R8 abort in data and command phase
        wr_reg(6'h01, 24'h5A); m_ioset = 8'h5A;
        cs_n = 1'b0; tick(4);
        shift(24'h01, 8, v); shift(24'hF, 4, v);
        cs_n = 1'b1; tick(6);
        cs_n = 1'b0; tick(4);
        shift(24'h0, 5, v);
        cs_n = 1'b1; tick(6);
        rd_reg(6'h01, v); check("R8 aborted access", v, 24'h5A);

        // R10 back-to-back under one select
        cs_n = 1'b0; tick(4);
        frame(8'h41, 24'h0, v);
        frame(8'h46, 24'h0, v2);
        cs_n = 1'b1; tick(6);
        check("R10 first frame", v, 24'h5A);
        check("R10 second frame", v2, 24'h123456);

        // R11 snapshot at end of command
        wide_data = 1'b1;
        cs_n = 1'b0; tick(4);
        shift(24'h48, 8, v);
        chan0_data = 24'h3C3C3C;
        shift(24'h0, 24, v);
        cs_n = 1'b1; tick(6);
        check("R11 snapshot", v, 24'hA5C3E1);

        // R7 31 ones: no reset
        cs_n = 1'b0; tick(4);
        shift(24'hFFFFFF, 24, v); shift(24'hFF, 7, v);
        cs_n = 1'b1; tick(6);
        rd_reg(6'h01, v); check("R7 31 ones keep state", v, 24'h5A);
        // R7 32 ones: reset, then a command in the same session
        cs_n = 1'b0; tick(4);
        shift(24'hFFFFFF, 24, v); shift(24'hFF, 8, v);
        frame(8'h41, 24'h0, v);
        cs_n = 1'b1; tick(6);
        check("R7 resync defaults", v, 24'h30);
        model_defaults();
        check_all("R7 resync defaults");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule